// File: doc/BRIEF.md
# Poison-Tagged Register File

This block is an architectural register file in which every entry keeps a one-bit poison flag next to its data word. Only committed results write it. A committing result whose fault tag is set is stored with its poison flag raised. No error is signalled at that point. The error is raised later, when an instruction actually reads the poisoned entry. A poisoned value that is overwritten before anyone reads it therefore never produces an error.

There is one write port with a poison input and two combinational read ports, each with its own enable. A single error output reports whether any enabled read hit a poisoned entry, and it gives the index of the offending register. Register 0 always reads as zero and can never hold poison. A read of the entry being written in the same cycle sees the incoming data and the incoming poison flag.

Top module: `rf_taint_file`

## Requirements
- R1: A write with `wr_en`=1, a non-zero `wr_addr` and `wr_poison`=1 stores the data with the poison flag set. A later enabled read of that register returns the data, drives `err_valid`=1 and places the register index on `err_idx`.
- R2: A write with `wr_poison`=0 clears the poison flag of the destination register, so later reads of it raise no error.
- R3: A poisoned register that is overwritten by a clean write before any read never causes `err_valid` to rise.
- R4: Register 0 reads as all zeros on both ports and never raises an error, even after a poisoned write addressed to it.
- R5: When a read port addresses the register being written in the same cycle, it returns the incoming `wr_data`, and its error contribution follows the incoming `wr_poison` (write-first).
- R6: When both read ports hit poisoned registers in the same cycle, `err_idx` carries the read-port-0 address.
- R7: Reset (asynchronous, `rst_n` low) clears every poison flag and every data word to zero.
- R8: A read port with its enable low never contributes to `err_valid`. Its data output still shows the addressed register.
- R9: While `wr_en` is low, no register data or poison flag changes.
- R10: While `err_valid` is 0, `err_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Commit write strobe |
| wr_addr | input | AW (5) | Destination register index |
| wr_data | input | WIDTH (32) | Result value to store |
| wr_poison | input | 1 | Fault tag carried by the committing result |
| rd0_en | input | 1 | Read port 0 consumer read valid |
| rd0_addr | input | AW (5) | Read port 0 register index |
| rd0_data | output | WIDTH (32) | Read port 0 data |
| rd1_en | input | 1 | Read port 1 consumer read valid |
| rd1_addr | input | AW (5) | Read port 1 register index |
| rd1_data | output | WIDTH (32) | Read port 1 data |
| err_valid | output | 1 | An enabled read touched a poisoned register |
| err_idx | output | AW (5) | Index of the offending register |

## Verification
The bench poisons a register and then overwrites it cleanly before any read. A design that raised its error at write time, or failed to clear the flag on a clean write, would report a false error here. It reads an entry in the same cycle it is written, both with poison and without it. A read-first design would return stale data there, or report stale poison. It also drives both ports at poisoned entries at once, in both orders and with one enable low. A reversed priority encoder would name the port-1 register, and an ungated read would flag a register that no consumer read. Register 0 receives a poisoned write and is read directly and through the same-cycle path, where a missing hardwire would leak data or poison.

// File: rtl/rft_pkg.sv
package rft_pkg;
    // Default geometry of the poison-tagged register file
    localparam int unsigned RFT_NREGS  = 32;
    localparam int unsigned RFT_WIDTH  = 32;
    localparam int unsigned RFT_NPORTS = 2;
endpackage

// File: rtl/rft_store.sv
module rft_store #(
    parameter int unsigned NREGS = rft_pkg::RFT_NREGS,
    parameter int unsigned WIDTH = rft_pkg::RFT_WIDTH,
    parameter int unsigned AW    = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WIDTH-1:0]              wr_data,
    input  logic                          wr_poison,
    output logic [NREGS-1:0][WIDTH-1:0]   mem_data,
    output logic [NREGS-1:0]              mem_poison
);
    typedef struct packed {
        logic [NREGS-1:0][WIDTH-1:0] data;
        logic [NREGS-1:0]            poison;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr != '0)) begin
            st_d.data[wr_addr]   = wr_data;
            st_d.poison[wr_addr] = wr_poison;
        end
        // entry 0 is a constant zero and is never tagged
        st_d.data[0]   = '0;
        st_d.poison[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_data   = st_q.data;
    assign mem_poison = st_q.poison;

    // R1: a tagged write leaves the flag set on the destination
    p_poison_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_poison && (wr_addr != '0)) |=> mem_poison[$past(wr_addr)]);

    // R2: an untagged write leaves the flag clear on the destination
    p_clean_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_poison) |=> !mem_poison[$past(wr_addr)]);

    // R4: entry 0 never carries a flag or data
    p_zero_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_poison[0] && (mem_data[0] == '0));

    // R7: reset leaves every flag clear
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (mem_poison == '0));

    // R9: no write, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mem_poison) && $stable(mem_data)));
endmodule

// File: rtl/rft_rd_port.sv
module rft_rd_port #(
    parameter int unsigned NREGS = rft_pkg::RFT_NREGS,
    parameter int unsigned WIDTH = rft_pkg::RFT_WIDTH,
    parameter int unsigned AW    = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [AW-1:0]                 rd_addr,
    input  logic [NREGS-1:0][WIDTH-1:0]   mem_data,
    input  logic [NREGS-1:0]              mem_poison,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WIDTH-1:0]              wr_data,
    input  logic                          wr_poison,
    output logic [WIDTH-1:0]              rd_data,
    output logic                          rd_hit
);
    logic             fwd;
    logic             tag;

    always_comb begin
        fwd = wr_en && (wr_addr == rd_addr);
        if (rd_addr == '0) begin
            rd_data = '0;
            tag     = 1'b0;
        end else if (fwd) begin
            rd_data = wr_data;
            tag     = wr_poison;
        end else begin
            rd_data = mem_data[rd_addr];
            tag     = mem_poison[rd_addr];
        end
        rd_hit = rd_en && tag;
    end

    // R4: address 0 returns zero and never flags
    p_zero_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> ((rd_data == '0) && !rd_hit));

    // R2/R3: a clean stored entry that is not being written never flags
    p_clean_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_poison[rd_addr] && !wr_en) |-> !rd_hit);
endmodule

// File: rtl/rft_err_sel.sv
module rft_err_sel #(
    parameter int unsigned NPORTS = rft_pkg::RFT_NPORTS,
    parameter int unsigned AW     = 5
) (
    input  logic [NPORTS-1:0]          hit,
    input  logic [NPORTS-1:0][AW-1:0]  addr,
    output logic                       err_valid,
    output logic [AW-1:0]              err_idx
);
    always_comb begin
        err_idx = '0;
        // lowest-numbered port wins: scan from the top down
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (hit[i]) err_idx = addr[i];
        end
        err_valid = |hit;
    end
endmodule

// File: rtl/rf_taint_file.sv
module rf_taint_file #(
    parameter int unsigned NREGS = rft_pkg::RFT_NREGS,
    parameter int unsigned WIDTH = rft_pkg::RFT_WIDTH,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_poison,
    input  logic             rd0_en,
    input  logic [AW-1:0]    rd0_addr,
    output logic [WIDTH-1:0] rd0_data,
    input  logic             rd1_en,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_data,
    output logic             err_valid,
    output logic [AW-1:0]    err_idx
);
    localparam int unsigned NP = rft_pkg::RFT_NPORTS;

    logic [NREGS-1:0][WIDTH-1:0] mem_data;
    logic [NREGS-1:0]            mem_poison;
    logic [NP-1:0]               p_en;
    logic [NP-1:0][AW-1:0]       p_addr;
    logic [NP-1:0][WIDTH-1:0]    p_data;
    logic [NP-1:0]               p_hit;

    assign p_en[0]   = rd0_en;
    assign p_en[1]   = rd1_en;
    assign p_addr[0] = rd0_addr;
    assign p_addr[1] = rd1_addr;
    assign rd0_data  = p_data[0];
    assign rd1_data  = p_data[1];

    rft_store #(.NREGS(NREGS), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_poison  (wr_poison),
        .mem_data   (mem_data),
        .mem_poison (mem_poison)
    );

    for (genvar g = 0; g < NP; g++) begin : g_port
        rft_rd_port #(.NREGS(NREGS), .WIDTH(WIDTH), .AW(AW)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_en      (p_en[g]),
            .rd_addr    (p_addr[g]),
            .mem_data   (mem_data),
            .mem_poison (mem_poison),
            .wr_en      (wr_en),
            .wr_addr    (wr_addr),
            .wr_data    (wr_data),
            .wr_poison  (wr_poison),
            .rd_data    (p_data[g]),
            .rd_hit     (p_hit[g])
        );
    end

    rft_err_sel #(.NPORTS(NP), .AW(AW)) u_err (
        .hit       (p_hit),
        .addr      (p_addr),
        .err_valid (err_valid),
        .err_idx   (err_idx)
    );

    // R6: port 0 wins the report when it hits
    p_port0_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        p_hit[0] |-> (err_idx == rd0_addr));

    // R8: with no enabled reader there is no error
    p_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd0_en && !rd1_en) |-> !err_valid);

    // R10: idle index is zero
    p_idle_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> (err_idx == '0));

    // R1: a reported index always names an enabled reader's address
    p_idx_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> ((rd0_en && err_idx == rd0_addr) || (rd1_en && err_idx == rd1_addr)));
endmodule

// File: tb/sim_rf_taint_file.sv
module sim_rf_taint_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_poison = 1'b0;
    logic        rd0_en = 1'b0;
    logic [4:0]  rd0_addr = '0;
    logic [31:0] rd0_data;
    logic        rd1_en = 1'b0;
    logic [4:0]  rd1_addr = '0;
    logic [31:0] rd1_data;
    logic        err_valid;
    logic [4:0]  err_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;

    rf_taint_file u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_poison(wr_poison),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .err_valid(err_valid), .err_idx(err_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // commit one result; it lands at the posedge between two negedges
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_poison = p;
        @(negedge clk);
        wr_en = 1'b0; wr_poison = 1'b0;
    endtask

    // drive both read ports and let the combinational outputs settle
    task automatic rd(input logic e0, input logic [4:0] a0, input logic e1, input logic [4:0] a1);
        @(negedge clk);
        rd0_en = e0; rd0_addr = a0; rd1_en = e1; rd1_addr = a1;
        #1;
    endtask

    task automatic rd_idle();
        rd0_en = 1'b0; rd1_en = 1'b0; rd0_addr = '0; rd1_addr = '0;
    endtask

    task automatic t_reset();
        for (int r = 0; r < 32; r += 2) begin
            rd(1'b1, 5'(r), 1'b1, 5'(r + 1));
            chk("R7 data p0 after reset", rd0_data, 32'h0);
            chk("R7 data p1 after reset", rd1_data, 32'h0);
            chk("R7 no error after reset", {31'b0, err_valid}, 32'h0);
            chk("R10 idle idx", {27'b0, err_idx}, 32'h0);
        end
        rd_idle();
    endtask

    task automatic t_poison_read();
        wr(5'd5, 32'hA5A5_0005, 1'b1);
        rd(1'b0, 5'd0, 1'b0, 5'd0);
        chk("R1 no error before read", {31'b0, err_valid}, 32'h0);
        rd(1'b0, 5'd0, 1'b1, 5'd5);
        chk("R1 data", rd1_data, 32'hA5A5_0005);
        chk("R1 error raised", {31'b0, err_valid}, 32'h1);
        chk("R1 index", {27'b0, err_idx}, 32'd5);
        rd_idle();
    endtask

    task automatic t_clean_clear();
        wr(5'd5, 32'h0000_1234, 1'b0);
        rd(1'b1, 5'd5, 1'b0, 5'd0);
        chk("R2 data", rd0_data, 32'h0000_1234);
        chk("R2 no error", {31'b0, err_valid}, 32'h0);
        chk("R10 idle idx", {27'b0, err_idx}, 32'h0);
        rd_idle();
    endtask

    task automatic t_dead_value();
        wr(5'd9, 32'hDEAD_0009, 1'b1);
        wr(5'd9, 32'h600D_0009, 1'b0);
        rd(1'b1, 5'd9, 1'b1, 5'd9);
        chk("R3 new data", rd0_data, 32'h600D_0009);
        chk("R3 no error", {31'b0, err_valid}, 32'h0);
        rd_idle();
    endtask

    task automatic t_zero_reg();
        wr(5'd0, 32'hFFFF_FFFF, 1'b1);
        rd(1'b1, 5'd0, 1'b1, 5'd0);
        chk("R4 data p0", rd0_data, 32'h0);
        chk("R4 data p1", rd1_data, 32'h0);
        chk("R4 no error", {31'b0, err_valid}, 32'h0);
        // same-cycle write to entry 0 must not leak either
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h1357_9BDF; wr_poison = 1'b1;
        rd0_en = 1'b1; rd0_addr = 5'd0; rd1_en = 1'b0;
        #1;
        chk("R4 bypass data", rd0_data, 32'h0);
        chk("R4 bypass no error", {31'b0, err_valid}, 32'h0);
        @(negedge clk);
        wr_en = 1'b0; wr_poison = 1'b0; rd_idle();
    endtask

    task automatic t_bypass();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h7777_0001; wr_poison = 1'b1;
        rd0_en = 1'b1; rd0_addr = 5'd7; rd1_en = 1'b0;
        #1;
        chk("R5 new data", rd0_data, 32'h7777_0001);
        chk("R5 new poison flags", {31'b0, err_valid}, 32'h1);
        chk("R5 index", {27'b0, err_idx}, 32'd7);
        // r7 now poisoned; a clean write read in the same cycle must not flag
        @(negedge clk);
        wr_data = 32'h7777_0002; wr_poison = 1'b0;
        rd0_en = 1'b0; rd1_en = 1'b1; rd1_addr = 5'd7;
        #1;
        chk("R5 clean bypass data", rd1_data, 32'h7777_0002);
        chk("R5 clean bypass no error", {31'b0, err_valid}, 32'h0);
        @(negedge clk);
        wr_en = 1'b0; rd_idle();
    endtask

    task automatic t_priority();
        wr(5'd3, 32'h3333_3333, 1'b1);
        wr(5'd12, 32'hCCCC_CCCC, 1'b1);
        rd(1'b1, 5'd12, 1'b1, 5'd3);
        chk("R6 port0 index", {27'b0, err_idx}, 32'd12);
        rd(1'b1, 5'd3, 1'b1, 5'd12);
        chk("R6 port0 index swapped", {27'b0, err_idx}, 32'd3);
        rd(1'b0, 5'd3, 1'b1, 5'd12);
        chk("R8 disabled port0 yields port1 index", {27'b0, err_idx}, 32'd12);
        chk("R1 error on port1", {31'b0, err_valid}, 32'h1);
        rd_idle();
    endtask

    task automatic t_enable();
        rd(1'b0, 5'd3, 1'b0, 5'd12);
        chk("R8 no error when disabled", {31'b0, err_valid}, 32'h0);
        chk("R8 data still visible", rd0_data, 32'h3333_3333);
        chk("R10 idle idx", {27'b0, err_idx}, 32'h0);
        rd_idle();
    endtask

    task automatic t_no_write();
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd3; wr_data = 32'h0BAD_0BAD; wr_poison = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd(1'b1, 5'd3, 1'b0, 5'd0);
        chk("R9 data kept", rd0_data, 32'h3333_3333);
        chk("R9 poison kept", {31'b0, err_valid}, 32'h1);
        rd_idle();
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b1, 5'd3, 1'b1, 5'd12);
        chk("R7 poison cleared", {31'b0, err_valid}, 32'h0);
        chk("R7 data cleared", rd0_data, 32'h0);
        rd_idle();
    endtask

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_poison_read();
        t_clean_clear();
        t_dead_value();
        t_zero_reg();
        t_bypass();
        t_priority();
        t_enable();
        t_no_write();
        t_reset_again();
        repeat (2) @(negedge clk);
        report();
    end
endmodule